// File: doc/BRIEF.md
# UART Legacy Fallback Mode Controller

This block holds the operating-mode state of an enhanced 16550-style UART. When old software reaches for the classic baud divisor ports, the block drops the UART back to a legacy-safe setup on its own. Those ports sit in bank 1, and touching them by either a read or a write is enough. In that setup the FIFO depth is 16, the prescaler select is 13 and the test and loopback bits are clear. If the UART was in Extended mode, the block also leaves Extended mode and selects plain UART framing.

Software written for the extended feature set avoids a fallback by programming the divisor through a second pair of ports in bank 2. The same bank also holds a control byte (test, loopback, FIFO depth, serial mode) and the prescaler select. A lock input keeps a legacy program in Non-Extended mode from triggering a fallback. While it is set, the two legacy divisor addresses point at a pair of scratch bytes, and the divisor is not touched. The serial shifter, the FIFOs and the baud generator sit outside this block, which only drives their settings. A combinational read port returns the register selected by the current bank and offset.

Top module: `uart_mode_fallback`

## Requirements
- R1: After reset:
  - the block is in Non-Extended mode;
  - FIFO depth select is 0 (16 levels);
  - prescaler select is 13;
  - test, loopback and serial mode (0 = plain UART) are 0;
  - divisor and both scratch bytes are 0.
- R2: A read or write at bank 2, offset 0 (divisor low byte) or offset 1 (divisor high byte) reaches the divisor. It never produces a fallback event, and it never changes the mode.
- R3: A read or write at bank 1, offset 0 or 1, while in Extended mode always causes a fallback, whatever the lock input is. The fallback does all of the following:
  - leaves Extended mode;
  - sets serial mode to 0;
  - sets FIFO depth select to 0;
  - sets the prescaler select to 13;
  - clears test and loopback.
- R4: The same access in Non-Extended mode with lock at 0 causes a fallback. That fallback sets FIFO depth to 0 and prescaler to 13, and clears test and loopback. It leaves the serial mode and the mode bit unchanged.
- R5: In Non-Extended mode with lock at 1, bank 1 offsets 0 and 1 read and write two scratch bytes. No fallback event occurs, and the divisor and control settings keep their values.
- R6: A strobe (read or write) held high for several cycles produces exactly one fallback event pulse, one cycle wide.
- R7: The fallback settings and the event pulse appear on the clock edge that samples the first cycle of the access strobe.
- R8: A bank 1 write that is not redirected to scratch loads the divisor byte chosen by the offset (0 = low, 1 = high). This also holds for a write that triggers a fallback from Extended mode.
- R9: A mode write that requests Extended mode in the same cycle as a fallback from Extended mode loses: the block ends up in Non-Extended mode.
- R10: Bank 2 offset 2 is the control byte:
  - bit 0 is test;
  - bit 1 is loopback;
  - bit 2 is FIFO depth (1 = 32 levels);
  - bits 5:4 are serial mode.

  Bank 2 offset 3 bits 4:0 are the prescaler select. Both bytes read back through the read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_i | input | 2 | Register bank of the access |
| addr_i | input | 3 | Register offset within the bank |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register selected by bank and offset |
| mode_wr_i | input | 1 | Load the mode bit from mode_ext_i |
| mode_ext_i | input | 1 | Requested mode, 1 = Extended |
| lock_i | input | 1 | Suppress fallback in Non-Extended mode |
| ext_mode_o | output | 1 | 1 while in Extended mode |
| fifo_deep_o | output | 1 | FIFO depth select, 0 = 16 levels |
| presc_o | output | 5 | Baud prescaler select |
| test_o | output | 1 | Baud test control bit |
| lpbk_o | output | 1 | Loopback control bit |
| ser_mode_o | output | 2 | Serial mode select, 0 = plain UART |
| divisor_o | output | 16 | Baud divisor |
| fb_event_o | output | 1 | One-cycle pulse per fallback |

## Verification
The bench builds the block with its default parameters:
- an 8-bit bus;
- a two-byte divisor;
- a 5-bit prescaler field;
- a fallback prescaler value of 13.

These values put both divisor bytes, both scratch bytes and every control field within direct reach of register accesses. A fallback value of 13 differs from any prescaler value the bench writes beforehand, so a missing prescaler reset is visible. Held strobes, simultaneous mode writes and lock changes in each mode reach all of the fallback branches.

// File: rtl/uart_fb_pkg.sv
package uart_fb_pkg;

    typedef enum logic [1:0] {
        SER_UART = 2'd0,
        SER_ALT1 = 2'd1,
        SER_ALT2 = 2'd2,
        SER_ALT3 = 2'd3
    } ser_mode_e;

    localparam int CTRL_TEST_BIT = 0;
    localparam int CTRL_LPBK_BIT = 1;
    localparam int CTRL_FIFO_BIT = 2;
    localparam int CTRL_SER_LSB  = 4;

endpackage

// File: rtl/uart_fb_decode.sv
module uart_fb_decode #(
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 3,
    parameter int DIV_BYTES = 2,
    parameter int LEG_BANK  = 1,
    parameter int ALT_BANK  = 2,
    localparam int IDX_W    = (DIV_BYTES > 1) ? $clog2(DIV_BYTES) : 1
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              leg_hit_o,
    output logic              alt_hit_o,
    output logic              ctrl_hit_o,
    output logic              presc_hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [ADDR_W-1:0] DIV_TOP   = ADDR_W'(DIV_BYTES);
    localparam logic [ADDR_W-1:0] CTRL_OFF  = ADDR_W'(DIV_BYTES);
    localparam logic [ADDR_W-1:0] PRESC_OFF = ADDR_W'(DIV_BYTES + 1);

    logic in_div;
    logic in_leg;
    logic in_alt;

    always_comb begin
        in_div      = (addr_i < DIV_TOP);
        in_leg      = (bank_i == BANK_W'(LEG_BANK));
        in_alt      = (bank_i == BANK_W'(ALT_BANK));
        leg_hit_o   = in_leg && in_div;
        alt_hit_o   = in_alt && in_div;
        ctrl_hit_o  = in_alt && (addr_i == CTRL_OFF);
        presc_hit_o = in_alt && (addr_i == PRESC_OFF);
        idx_o       = addr_i[IDX_W-1:0];
    end
endmodule

// File: rtl/uart_fb_edge.sv
module uart_fb_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic start_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d  = strobe_i;
        start_o = strobe_i && !prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/uart_fb_rdmux.sv
module uart_fb_rdmux #(
    parameter int DATA_W    = 8,
    parameter int DIV_BYTES = 2,
    parameter int PRESC_W   = 5,
    localparam int DIV_W    = DATA_W * DIV_BYTES,
    localparam int IDX_W    = (DIV_BYTES > 1) ? $clog2(DIV_BYTES) : 1
) (
    input  logic               leg_hit_i,
    input  logic               alt_hit_i,
    input  logic               ctrl_hit_i,
    input  logic               presc_hit_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               use_scr_i,
    input  logic [DIV_W-1:0]   div_i,
    input  logic [DIV_W-1:0]   scr_i,
    input  logic [DATA_W-1:0]  ctrl_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic [DATA_W-1:0]  rdata_o
);
    logic [DATA_W-1:0] div_b [DIV_BYTES];
    logic [DATA_W-1:0] scr_b [DIV_BYTES];

    for (genvar b = 0; b < DIV_BYTES; b++) begin : g_lane
        assign div_b[b] = div_i[b*DATA_W +: DATA_W];
        assign scr_b[b] = scr_i[b*DATA_W +: DATA_W];
    end

    always_comb begin
        rdata_o = '0;
        if (leg_hit_i)        rdata_o = use_scr_i ? scr_b[idx_i] : div_b[idx_i];
        else if (alt_hit_i)   rdata_o = div_b[idx_i];
        else if (ctrl_hit_i)  rdata_o = ctrl_i;
        else if (presc_hit_i) rdata_o = DATA_W'(presc_i);
    end
endmodule

// File: rtl/uart_mode_fallback.sv
module uart_mode_fallback #(
    parameter int DATA_W    = 8,
    parameter int DIV_BYTES = 2,
    parameter int PRESC_W   = 5,
    parameter int FB_PRESC  = 13,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 3,
    parameter int LEG_BANK  = 1,
    parameter int ALT_BANK  = 2,
    localparam int DIV_W    = DATA_W * DIV_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BANK_W-1:0]  bank_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic               mode_wr_i,
    input  logic               mode_ext_i,
    input  logic               lock_i,
    output logic               ext_mode_o,
    output logic               fifo_deep_o,
    output logic [PRESC_W-1:0] presc_o,
    output logic               test_o,
    output logic               lpbk_o,
    output logic [1:0]         ser_mode_o,
    output logic [DIV_W-1:0]   divisor_o,
    output logic               fb_event_o
);
    import uart_fb_pkg::*;

    localparam int IDX_W = (DIV_BYTES > 1) ? $clog2(DIV_BYTES) : 1;

    typedef struct packed {
        logic               ext;
        logic               fifo_deep;
        logic [PRESC_W-1:0] presc;
        logic               test;
        logic               lpbk;
        ser_mode_e          ser;
        logic [DIV_W-1:0]   div;
        logic [DIV_W-1:0]   scr;
        logic               fb;
    } state_t;

    state_t st_d, st_q;

    logic             leg_hit, alt_hit, ctrl_hit, presc_hit;
    logic [IDX_W-1:0] idx;
    logic             start;
    logic             use_scr;
    logic [DATA_W-1:0] ctrl_view;

    uart_fb_decode #(
        .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DIV_BYTES(DIV_BYTES),
        .LEG_BANK(LEG_BANK), .ALT_BANK(ALT_BANK)
    ) u_dec (
        .bank_i(bank_i), .addr_i(addr_i),
        .leg_hit_o(leg_hit), .alt_hit_o(alt_hit),
        .ctrl_hit_o(ctrl_hit), .presc_hit_o(presc_hit),
        .idx_o(idx)
    );

    uart_fb_edge u_edge (
        .clk(clk), .rst_n(rst_n),
        .strobe_i(rd_i || wr_i),
        .start_o(start)
    );

    always_comb begin
        ctrl_view                              = '0;
        ctrl_view[CTRL_TEST_BIT]               = st_q.test;
        ctrl_view[CTRL_LPBK_BIT]               = st_q.lpbk;
        ctrl_view[CTRL_FIFO_BIT]               = st_q.fifo_deep;
        ctrl_view[CTRL_SER_LSB +: 2]           = st_q.ser;
    end

    uart_fb_rdmux #(
        .DATA_W(DATA_W), .DIV_BYTES(DIV_BYTES), .PRESC_W(PRESC_W)
    ) u_rd (
        .leg_hit_i(leg_hit), .alt_hit_i(alt_hit),
        .ctrl_hit_i(ctrl_hit), .presc_hit_i(presc_hit),
        .idx_i(idx), .use_scr_i(use_scr),
        .div_i(st_q.div), .scr_i(st_q.scr),
        .ctrl_i(ctrl_view), .presc_i(st_q.presc),
        .rdata_o(rdata_o)
    );

    // Next-state computation: mode write, register writes, then fallback
    // (fallback overrides anything written earlier in the same cycle).
    always_comb begin
        st_d    = st_q;
        st_d.fb = 1'b0;
        use_scr = lock_i && !st_q.ext;

        if (mode_wr_i) st_d.ext = mode_ext_i;

        if (wr_i) begin
            if (leg_hit) begin
                if (use_scr) st_d.scr[idx*DATA_W +: DATA_W] = wdata_i;
                else         st_d.div[idx*DATA_W +: DATA_W] = wdata_i;
            end
            if (alt_hit) st_d.div[idx*DATA_W +: DATA_W] = wdata_i;
            if (ctrl_hit) begin
                st_d.test      = wdata_i[CTRL_TEST_BIT];
                st_d.lpbk      = wdata_i[CTRL_LPBK_BIT];
                st_d.fifo_deep = wdata_i[CTRL_FIFO_BIT];
                st_d.ser       = ser_mode_e'(wdata_i[CTRL_SER_LSB +: 2]);
            end
            if (presc_hit) st_d.presc = wdata_i[PRESC_W-1:0];
        end

        if (start && leg_hit && !use_scr) begin
            st_d.fb        = 1'b1;
            st_d.fifo_deep = 1'b0;
            st_d.presc     = PRESC_W'(FB_PRESC);
            st_d.test      = 1'b0;
            st_d.lpbk      = 1'b0;
            if (st_q.ext) begin
                st_d.ext = 1'b0;
                st_d.ser = SER_UART;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ext       <= 1'b0;
            st_q.fifo_deep <= 1'b0;
            st_q.presc     <= PRESC_W'(FB_PRESC);
            st_q.test      <= 1'b0;
            st_q.lpbk      <= 1'b0;
            st_q.ser       <= SER_UART;
            st_q.div       <= '0;
            st_q.scr       <= '0;
            st_q.fb        <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ext_mode_o  = st_q.ext;
    assign fifo_deep_o = st_q.fifo_deep;
    assign presc_o     = st_q.presc;
    assign test_o      = st_q.test;
    assign lpbk_o      = st_q.lpbk;
    assign ser_mode_o  = st_q.ser;
    assign divisor_o   = st_q.div;
    assign fb_event_o  = st_q.fb;
endmodule

// File: rtl/uart_fb_chk.sv
module uart_fb_chk #(
    parameter int PRESC_W   = 5,
    parameter int FB_PRESC  = 13,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 3,
    parameter int DIV_BYTES = 2,
    parameter int DIV_W     = 16,
    parameter int LEG_BANK  = 1,
    parameter int ALT_BANK  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [BANK_W-1:0]  bank_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               rd_i,
    input logic               wr_i,
    input logic               mode_wr_i,
    input logic               lock_i,
    input logic               ext_mode_o,
    input logic               fifo_deep_o,
    input logic [PRESC_W-1:0] presc_o,
    input logic               test_o,
    input logic               lpbk_o,
    input logic [1:0]         ser_mode_o,
    input logic [DIV_W-1:0]   divisor_o,
    input logic               fb_event_o
);
    logic leg_acc, alt_acc;
    assign leg_acc = (rd_i || wr_i) && bank_i == BANK_W'(LEG_BANK) && addr_i < ADDR_W'(DIV_BYTES);
    assign alt_acc = (rd_i || wr_i) && bank_i == BANK_W'(ALT_BANK) && addr_i < ADDR_W'(DIV_BYTES);

    // R6
    fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_event_o |=> !fb_event_o);

    // R7
    fb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_event_o |-> $past(leg_acc));

    // R3
    ext_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_event_o && $past(ext_mode_o)) |-> (!ext_mode_o && ser_mode_o == 2'd0));

    // R4
    fb_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_event_o |-> (presc_o == PRESC_W'(FB_PRESC) && !fifo_deep_o && !test_o && !lpbk_o));

    // R4
    nonext_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_event_o && !$past(ext_mode_o) && !$past(mode_wr_i)) |-> (!ext_mode_o && $stable(ser_mode_o)));

    // R5
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_i && !ext_mode_o && leg_acc) |-> (!fb_event_o && $stable(divisor_o)));

    // R2
    alt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(alt_acc) |-> !fb_event_o);
endmodule

bind uart_mode_fallback uart_fb_chk #(
    .PRESC_W(PRESC_W), .FB_PRESC(FB_PRESC), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
    .DIV_BYTES(DIV_BYTES), .DIV_W(DIV_W), .LEG_BANK(LEG_BANK), .ALT_BANK(ALT_BANK)
) u_chk (.*);

// File: tb/uart_mode_fallback_tb.sv
module uart_mode_fallback_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bank_i = '0;
    logic [2:0]  addr_i = '0;
    logic        rd_i = 1'b0, wr_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic        mode_wr_i = 1'b0, mode_ext_i = 1'b0, lock_i = 1'b0;
    logic        ext_mode_o, fifo_deep_o, test_o, lpbk_o, fb_event_o;
    logic [4:0]  presc_o;
    logic [1:0]  ser_mode_o;
    logic [15:0] divisor_o;

    always #2 clk = ~clk;

    uart_mode_fallback u_dut (
        .clk(clk), .rst_n(rst_n), .bank_i(bank_i), .addr_i(addr_i),
        .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .mode_wr_i(mode_wr_i), .mode_ext_i(mode_ext_i), .lock_i(lock_i),
        .ext_mode_o(ext_mode_o), .fifo_deep_o(fifo_deep_o), .presc_o(presc_o),
        .test_o(test_o), .lpbk_o(lpbk_o), .ser_mode_o(ser_mode_o),
        .divisor_o(divisor_o), .fb_event_o(fb_event_o)
    );

    typedef struct {
        string       req;
        logic [35:0] exp;
        logic [35:0] mask;
    } item_t;
    item_t sb[$];

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // reference model, driven from the requirements
    logic        m_ext = 0, m_fifo = 0, m_test = 0, m_lpbk = 0;
    logic [4:0]  m_presc = 5'd13;
    logic [1:0]  m_ser = 0;
    logic [7:0]  m_div [2] = '{8'h00, 8'h00};
    logic [7:0]  m_scr [2] = '{8'h00, 8'h00};

    function automatic logic [7:0] exp_rd(int bank, int addr);
        if (bank == 1 && addr < 2) return (lock_i && !m_ext) ? m_scr[addr] : m_div[addr];
        if (bank == 2 && addr < 2) return m_div[addr];
        if (bank == 2 && addr == 2) return {2'b00, m_ser, 1'b0, m_fifo, m_lpbk, m_test};
        if (bank == 2 && addr == 3) return {3'b000, m_presc};
        return 8'h00;
    endfunction

    task automatic push(string req, logic [7:0] rd, bit rd_valid, logic fb);
        item_t it;
        it.req  = req;
        it.exp  = {m_ext, m_fifo, m_presc, m_test, m_lpbk, m_ser, m_div[1], m_div[0], rd, fb};
        it.mask = rd_valid ? '1 : ~(36'hFF << 1);
        sb.push_back(it);
    endtask

    // monitor: compares queued expectations a little after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [35:0] act;
                it  = sb.pop_front();
                act = {ext_mode_o, fifo_deep_o, presc_o, test_o, lpbk_o, ser_mode_o,
                       divisor_o, rdata_o, fb_event_o};
                n_run++;
                if (((act ^ it.exp) & it.mask) != 0) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    task automatic access(string req, int bank, int addr, bit wr, logic [7:0] data,
                          int hold, bit mw, bit mv);
        bit leg, fb, scr;
        @(negedge clk);
        bank_i = 2'(bank); addr_i = 3'(addr); rd_i = !wr; wr_i = wr; wdata_i = data;
        mode_wr_i = mw; mode_ext_i = mv;
        leg = (bank == 1 && addr < 2);
        scr = lock_i && !m_ext;
        fb  = leg && !scr;
        if (mw) m_ext = mv;
        if (wr) begin
            if (leg && scr) m_scr[addr] = data;
            else if (addr < 2 && (bank == 1 || bank == 2)) m_div[addr] = data;
            if (bank == 2 && addr == 2) begin
                m_test = data[0]; m_lpbk = data[1]; m_fifo = data[2]; m_ser = data[5:4];
            end
            if (bank == 2 && addr == 3) m_presc = data[4:0];
        end
        if (fb) begin
            m_fifo = 0; m_presc = 5'd13; m_test = 0; m_lpbk = 0;
            if (!scr && lock_i == lock_i && (bank == 1)) begin end
        end
        if (fb && mw == 0) begin end
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            mode_wr_i = 0;
            push(req, 8'h00, 0, (i == 0) ? fb : 1'b0);
        end
        rd_i = 0; wr_i = 0;
    endtask

    // fallback mode effect is applied separately so the model follows R3/R9 order
    task automatic legacy(string req, int addr, bit wr, logic [7:0] data, int hold, bit mw, bit mv);
        bit was_ext;
        was_ext = m_ext;
        if (was_ext) begin
            // R3 and R9: leaving Extended mode wins over a mode write
            fork
                access(req, 1, addr, wr, data, hold, mw, mv);
                begin
                    @(negedge clk);
                    m_ext = 0; m_ser = 0;
                end
            join
        end else begin
            access(req, 1, addr, wr, data, hold, mw, mv);
        end
    endtask

    task automatic set_mode(bit v);
        @(negedge clk);
        mode_wr_i = 1; mode_ext_i = v;
        @(negedge clk);
        mode_wr_i = 0;
        m_ext = v;
    endtask

    task automatic rd_check(string req, int bank, int addr);
        @(negedge clk);
        bank_i = 2'(bank); addr_i = 3'(addr); rd_i = 0; wr_i = 0;
        push(req, exp_rd(bank, addr), 1, 1'b0);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd_check("R1 reset", 1, 0);
        rd_check("R1 reset ctrl", 2, 2);

        // R10: control byte and prescaler layout
        access("R10 ctrl write", 2, 2, 1, 8'h37, 1, 0, 0);
        access("R10 presc write", 2, 3, 1, 8'h05, 1, 0, 0);
        rd_check("R10 ctrl read", 2, 2);
        rd_check("R10 presc read", 2, 3);
        set_mode(1);

        // R2: alternate divisor, no fallback
        access("R2 alt low", 2, 0, 1, 8'h34, 1, 0, 0);
        access("R2 alt high", 2, 1, 1, 8'h12, 1, 0, 0);
        access("R2 alt read", 2, 0, 0, 8'h00, 1, 0, 0);
        rd_check("R2 alt readback", 2, 1);

        // R3, R6, R7: held legacy read in Extended mode with lock set
        lock_i = 1;
        legacy("R3 R6 R7 ext fallback", 0, 0, 8'h00, 3, 0, 0);

        // R4, R8: Non-Extended fallback, lock clear
        lock_i = 0;
        access("R4 ctrl reload", 2, 2, 1, 8'h37, 1, 0, 0);
        legacy("R4 R8 nonext fallback", 1, 1, 8'h56, 1, 0, 0);
        rd_check("R4 ctrl after", 2, 2);

        // R5: lock redirects to scratch
        access("R5 ctrl reload", 2, 2, 1, 8'h37, 1, 0, 0);
        lock_i = 1;
        legacy("R5 scratch low", 0, 1, 8'hAA, 2, 0, 0);
        legacy("R5 scratch high", 1, 1, 8'h55, 1, 0, 0);
        rd_check("R5 scratch read low", 1, 0);
        rd_check("R5 scratch read high", 1, 1);
        rd_check("R5 divisor kept", 2, 0);
        rd_check("R5 ctrl kept", 2, 2);

        // R9: fallback from Extended beats a simultaneous mode write
        lock_i = 0;
        set_mode(1);
        legacy("R9 mode write loses", 0, 0, 8'h00, 1, 1, 1);

        // R8: legacy write in Extended mode with lock set reaches the divisor
        set_mode(1);
        lock_i = 1;
        legacy("R8 ext legacy write", 0, 1, 8'h77, 1, 0, 0);
        rd_check("R8 divisor read", 2, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule